// File: doc/BRIEF.md
# Wavetable Synthesizer Indirect Register Port

This block is the host-facing register front end of a wavetable synthesizer. The host sees four narrow ports on one simple synchronous bus: a register-select port, a byte data port, a halfword data port and a sample-memory data port. Behind the select port sits an indirect register file. It holds a bank of per-voice registers (control, frequency, loop start, loop end, position, volume, ramp control), chosen through a voice-select register, plus a few global registers. The globals are the sample-memory pointer (two registers), the active-voice register and the voice select itself.

The host first writes a register number to the select port and then moves data through one of the data ports. Bit 7 of the select value marks a readback: the same register is written with bit 7 clear and read with bit 7 set. Voice addresses are 24-bit values split over two halfword registers with an offset bit alignment. The sample memory is a small byte array indexed by the low bits of a 24-bit pointer. The block also derives the active voice count and the playback rate that goes with it.

Top module: `wt_regport`

## Requirements
- R1: Writing port 0 (select) stores bits 7:0 of the write data; reading port 0 returns the stored select value on bits 7:0 with bits 15:8 zero. Port codes: 0 select, 1 byte data, 2 halfword data, 3 sample-memory data.
- R2: A write on port 1 or 2 changes a register only when select bit 7 is clear. A read on port 1 or 2 returns the register named by select bits 6:0 only when select bit 7 is set, and returns zero otherwise.
- R3: Halfword registers are frequency 0x01, volume 0x09, the address halves and pointer-low 0x43. All others are byte registers. A halfword-port write to a byte register stores the low byte, and a halfword-port read returns it zero-extended. A byte-port write to a halfword register replaces only its high byte, and a byte-port read returns that high byte.
- R4: Voice select (0x4A, bits 4:0) picks which of 32 voices the per-voice registers address. Control 0x00 and ramp control 0x0D are bytes. Each voice keeps its own copy of every per-voice register.
- R5: Loop start (0x02/0x03), loop end (0x04/0x05) and position (0x0A/0x0B) each hold a 24-bit address A. The first register holds A[23:11] in bits 12:0 and reads bits 15:13 as zero. The second holds A[10:0] in bits 15:5 and reads bits 4:0 as zero.
- R6: The sample-memory pointer is pointer-low 0x43 (bits 15:0) and pointer-high 0x44 (bits 23:16). Both read back as written.
- R7: A write to port 3 stores bits 7:0 at the pointer. A read of port 3 returns the byte at the pointer. Only the low 8 pointer bits index the 256-byte memory.
- R8: Active-voice register 0x0E reads back as written. The voice count output is (bits 4:0) + 1, clamped to the range 14 to 32.
- R9: The playback rate output equals floor(617400 / voice count): 44100 at 14 voices, 19293 at 32 voices.
- R10: Register numbers outside the map read as zero, and writes to them change no register.
- R11: Reset clears the select, voice select, pointer, active-voice and all per-voice registers. After reset the outputs show 14 voices at 44100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed port |
| bus_port | input | 2 | Port code: 0 select, 1 byte data, 2 halfword data, 3 sample memory |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed port, combinational |
| active_voices | output | 6 | Clamped active voice count |
| playback_rate | output | 16 | Playback rate in Hz for the current voice count |

## Verification
The embedded assertions watch, on every cycle, that the voice count and rate stay inside their clamped ranges. They also check that select writes land, that a data write under a readback select leaves the global registers untouched, that a sample-memory write reaches the addressed byte, and that an unmapped register reads zero. The bench scenarios cover what needs a full register history: bank isolation across all 32 voices, the address split-and-rejoin round trip, mixed-width accesses, the stop read-modify-write, the full active-voice sweep against computed rates, and pointer aliasing across the whole byte array.

// File: rtl/wt_regport.sv
module wt_regport #(
  parameter int VOICES  = 32,
  parameter int DRAM_AW = 8,
  parameter int MIN_V   = 14,
  parameter int MAX_V   = 32,
  parameter int RATE_K  = 617400
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic [1:0]  bus_port,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic [5:0]  active_voices,
  output logic [15:0] playback_rate
);
  localparam int VW = $clog2(VOICES);
  localparam int DEPTH = 1 << DRAM_AW;

  logic [7:0]    sel_q, act_q, dhi_q;
  logic [15:0]   dlo_q;
  logic [VW-1:0] vsel_q;
  logic [7:0]    ctrl_q [VOICES];
  logic [7:0]    ramp_q [VOICES];
  logic [15:0]   freq_q [VOICES];
  logic [15:0]   vol_q  [VOICES];
  logic [23:0]   ls_q   [VOICES];
  logic [23:0]   le_q   [VOICES];
  logic [23:0]   pos_q  [VOICES];
  logic [7:0]    mem_q  [DEPTH];

  wire [6:0]  idx   = sel_q[6:0];
  wire        rsel  = sel_q[7];
  wire        p16   = bus_port == 2'd2;
  wire        dwr   = bus_wr && (bus_port == 2'd1 || p16) && !rsel;
  wire [23:0] ptr   = {dhi_q, dlo_q};

  logic [15:0] rv;
  logic        r16, hit;

  always_comb begin
    rv = 16'h0; r16 = 1'b0; hit = 1'b1;
    case (idx)
      7'h00: rv = {8'h0, ctrl_q[vsel_q]};
      7'h01: begin rv = freq_q[vsel_q]; r16 = 1'b1; end
      7'h02: begin rv = {3'b0, ls_q[vsel_q][23:11]}; r16 = 1'b1; end
      7'h03: begin rv = {ls_q[vsel_q][10:0], 5'b0}; r16 = 1'b1; end
      7'h04: begin rv = {3'b0, le_q[vsel_q][23:11]}; r16 = 1'b1; end
      7'h05: begin rv = {le_q[vsel_q][10:0], 5'b0}; r16 = 1'b1; end
      7'h09: begin rv = vol_q[vsel_q]; r16 = 1'b1; end
      7'h0A: begin rv = {3'b0, pos_q[vsel_q][23:11]}; r16 = 1'b1; end
      7'h0B: begin rv = {pos_q[vsel_q][10:0], 5'b0}; r16 = 1'b1; end
      7'h0D: rv = {8'h0, ramp_q[vsel_q]};
      7'h0E: rv = {8'h0, act_q};
      7'h43: begin rv = dlo_q; r16 = 1'b1; end
      7'h44: rv = {8'h0, dhi_q};
      7'h4A: rv = {{(16-VW){1'b0}}, vsel_q};
      default: hit = 1'b0;
    endcase
  end

  wire [15:0] wv = p16 ? bus_wdata : {bus_wdata[7:0], rv[7:0]};
  wire [7:0]  wb = bus_wdata[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0; act_q <= '0; dhi_q <= '0; dlo_q <= '0; vsel_q <= '0;
      for (int v = 0; v < VOICES; v++) begin
        ctrl_q[v] <= '0; ramp_q[v] <= '0; freq_q[v] <= '0; vol_q[v] <= '0;
        ls_q[v] <= '0; le_q[v] <= '0; pos_q[v] <= '0;
      end
    end else begin
      if (bus_wr && bus_port == 2'd0) sel_q <= wb;
      if (dwr) begin
        case (idx)
          7'h00: ctrl_q[vsel_q] <= wb;
          7'h01: freq_q[vsel_q] <= wv;
          7'h02: ls_q[vsel_q][23:11] <= wv[12:0];
          7'h03: ls_q[vsel_q][10:0] <= wv[15:5];
          7'h04: le_q[vsel_q][23:11] <= wv[12:0];
          7'h05: le_q[vsel_q][10:0] <= wv[15:5];
          7'h09: vol_q[vsel_q] <= wv;
          7'h0A: pos_q[vsel_q][23:11] <= wv[12:0];
          7'h0B: pos_q[vsel_q][10:0] <= wv[15:5];
          7'h0D: ramp_q[vsel_q] <= wb;
          7'h0E: act_q <= wb;
          7'h43: dlo_q <= wv;
          7'h44: dhi_q <= wb;
          7'h4A: vsel_q <= wb[VW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk)
    if (bus_wr && bus_port == 2'd3) mem_q[ptr[DRAM_AW-1:0]] <= wb;

  always_comb begin
    case (bus_port)
      2'd0: bus_rdata = {8'h0, sel_q};
      2'd1: bus_rdata = rsel ? {8'h0, (r16 ? rv[15:8] : rv[7:0])} : 16'h0;
      2'd2: bus_rdata = rsel ? (r16 ? rv : {8'h0, rv[7:0]}) : 16'h0;
      default: bus_rdata = {8'h0, mem_q[ptr[DRAM_AW-1:0]]};
    endcase
  end

  wire [5:0] raw = {1'b0, act_q[4:0]} + 6'd1;
  assign active_voices = (raw < 6'(MIN_V)) ? 6'(MIN_V) : (raw > 6'(MAX_V)) ? 6'(MAX_V) : raw;
  assign playback_rate = 16'(32'(RATE_K) / 32'(active_voices));

  a_r8_count_range: assert property (@(posedge clk) disable iff (rst)
    active_voices >= 6'(MIN_V) && active_voices <= 6'(MAX_V));
  a_r9_rate_range: assert property (@(posedge clk) disable iff (rst)
    playback_rate <= 16'(RATE_K / MIN_V) && playback_rate >= 16'(RATE_K / MAX_V));
  a_r1_sel_capture: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_port == 2'd0 |=> sel_q == $past(bus_wdata[7:0]));
  a_r2_readsel_no_write: assert property (@(posedge clk) disable iff (rst)
    bus_wr && (bus_port == 2'd1 || bus_port == 2'd2) && sel_q[7]
    |=> $stable(dlo_q) && $stable(dhi_q) && $stable(act_q) && $stable(vsel_q));
  a_r7_mem_store: assert property (@(posedge clk) disable iff (rst)
    bus_wr && bus_port == 2'd3 |=> mem_q[$past(ptr[DRAM_AW-1:0])] == $past(bus_wdata[7:0]));
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    !hit && (bus_port == 2'd1 || bus_port == 2'd2) |-> bus_rdata == 16'h0);
endmodule

// File: tb/wt_regport_tb_top.sv
module wt_regport_tb_top;
  logic clk = 1'b0, rst = 1'b1, bus_wr = 1'b0;
  logic [1:0] bus_port = 2'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata, playback_rate;
  logic [5:0] active_voices;
  int checks = 0, errors = 0;
  logic [7:0] exp_mem [256];

  always #4 clk = ~clk;

  wt_regport dut_i (.clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_port(bus_port),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .active_voices(active_voices),
    .playback_rate(playback_rate));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [15:0] d);
    bus_port = p; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #2; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, output logic [15:0] d);
    bus_port = p; #1; d = bus_rdata;
  endtask

  task automatic wreg(input logic [7:0] r, input logic [1:0] p, input logic [15:0] d);
    wr(2'd0, {8'h0, r}); wr(p, d);
  endtask

  task automatic rreg(input logic [7:0] r, input logic [1:0] p, output logic [15:0] d);
    wr(2'd0, {8'h0, r | 8'h80}); rd(p, d);
  endtask

  function automatic logic [23:0] addr_of(input int v, input int k);
    return 24'((v * 32'h3579B + k * 32'h11F0D3 + 32'h123) & 32'hFFFFFF);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, hi, lo;
    logic [23:0] a;
    repeat (3) @(posedge clk); #2; rst = 1'b0;

    rd(2'd0, d); chk("R11 select after reset", d, 0);
    chk("R11 voices after reset", active_voices, 14);
    chk("R11 rate after reset", playback_rate, 44100);
    rreg(8'h01, 2'd2, d); chk("R11 freq after reset", d, 0);
    rreg(8'h43, 2'd2, d); chk("R11 pointer low after reset", d, 0);

    wr(2'd0, 16'hFF5A); rd(2'd0, d); chk("R1 select readback", d, 16'h005A);

    for (int v = 0; v < 32; v++) begin
      wreg(8'h4A, 2'd1, 16'(v));
      wreg(8'h00, 2'd1, 16'((v * 3 + 1) & 8'hFF));
      wreg(8'h0D, 2'd2, 16'h5500 | 16'(v));
      wreg(8'h01, 2'd2, 16'(v * 16'h111 + 7));
      wreg(8'h09, 2'd2, 16'(16'hF000 - v * 16'h0101));
      for (int k = 0; k < 3; k++) begin
        a = addr_of(v, k);
        wreg(8'(2 + 2 * k + (k == 2 ? 4 : 0)), 2'd2, 16'(a >> 11));
        wreg(8'(3 + 2 * k + (k == 2 ? 4 : 0)), 2'd2, 16'(a << 5));
      end
    end
    for (int v = 0; v < 32; v++) begin
      wreg(8'h4A, 2'd1, 16'(v));
      rreg(8'h4A, 2'd1, d); chk("R4 voice select readback", d, v);
      rreg(8'h00, 2'd1, d); chk("R4 control per voice", d, (v * 3 + 1) & 8'hFF);
      rreg(8'h0D, 2'd2, d); chk("R3 R4 ramp low byte only", d, v);
      rreg(8'h01, 2'd2, d); chk("R4 frequency per voice", d, 16'(v * 16'h111 + 7));
      rreg(8'h09, 2'd2, d); chk("R4 volume per voice", d, 16'(16'hF000 - v * 16'h0101));
      for (int k = 0; k < 3; k++) begin
        a = addr_of(v, k);
        rreg(8'(2 + 2 * k + (k == 2 ? 4 : 0)), 2'd2, hi);
        rreg(8'(3 + 2 * k + (k == 2 ? 4 : 0)), 2'd2, lo);
        chk("R5 address upper half", hi, {3'b0, a[23:11]});
        chk("R5 address lower half", lo, {a[10:0], 5'b0});
        chk("R5 address rejoined", ((32'(hi) << 11) & 32'hFFF800) | ((32'(lo) >> 5) & 32'h7FF), a);
      end
    end

    wreg(8'h4A, 2'd1, 16'd9);
    wreg(8'h01, 2'd2, 16'h1234);
    wreg(8'h01, 2'd1, 16'hFFAB);
    rreg(8'h01, 2'd2, d); chk("R3 byte write to halfword keeps low byte", d, 16'hAB34);
    rreg(8'h01, 2'd1, d); chk("R3 byte read of halfword gives high byte", d, 16'h00AB);
    wreg(8'h00, 2'd2, 16'h77C3);
    rreg(8'h00, 2'd2, d); chk("R3 halfword access to byte register", d, 16'h00C3);

    wr(2'd0, 16'h0081); wr(2'd2, 16'h9999);
    rd(2'd2, d); chk("R2 write under read select ignored", d, 16'hAB34);
    wr(2'd0, 16'h0001); rd(2'd2, d); chk("R2 read without bit 7 is zero", d, 0);
    rd(2'd1, d); chk("R2 byte read without bit 7 is zero", d, 0);

    wreg(8'h00, 2'd1, 16'h00A4);
    rreg(8'h00, 2'd1, d);
    wreg(8'h00, 2'd1, 16'((d[7:0] | 8'h03) & ~8'hA0));
    rreg(8'h00, 2'd1, d); chk("R4 stop read-modify-write of control", d, 16'h0007);

    for (int n = 0; n < 32; n++) begin
      int c;
      c = (n + 1 < 14) ? 14 : (n + 1);
      wreg(8'h0E, 2'd1, 16'(8'hC0 | n));
      rreg(8'h0E, 2'd1, d); chk("R8 active register readback", d, 8'hC0 | n);
      chk("R8 clamped voice count", active_voices, c);
      chk("R9 playback rate", playback_rate, 617400 / c);
    end
    chk("R9 rate at 32 voices", playback_rate, 19293);

    wreg(8'h44, 2'd1, 16'h0012);
    for (int i = 0; i < 256; i++) begin
      wreg(8'h43, 2'd2, 16'(16'h3400 | i));
      exp_mem[i] = 8'((i * 7 + 3) & 8'hFF);
      wr(2'd3, {8'hEE, exp_mem[i]});
    end
    rreg(8'h44, 2'd1, d); chk("R6 pointer high readback", d, 16'h0012);
    rreg(8'h43, 2'd2, d); chk("R6 pointer low readback", d, 16'h34FF);
    wreg(8'h44, 2'd1, 16'h00A7);
    for (int i = 0; i < 256; i++) begin
      wreg(8'h43, 2'd2, 16'(16'h0100 | ((i * 37) & 8'hFF)));
      rd(2'd3, d); chk("R7 sample memory readback with aliasing", d, exp_mem[(i * 37) & 8'hFF]);
    end

    wreg(8'h4A, 2'd1, 16'd9);
    wreg(8'h20, 2'd2, 16'hBEEF);
    rreg(8'h20, 2'd2, d); chk("R10 unmapped reads zero", d, 0);
    rreg(8'h20, 2'd1, d); chk("R10 unmapped byte read zero", d, 0);
    rreg(8'h01, 2'd2, d); chk("R10 unmapped write left frequency", d, 16'hAB34);
    rreg(8'h43, 2'd2, d); chk("R10 unmapped write left pointer", d, 16'h01DB);

    rst = 1'b1; @(posedge clk); #2; rst = 1'b0;
    rreg(8'h0E, 2'd1, d); chk("R11 active register cleared", d, 0);
    rreg(8'h00, 2'd1, d); chk("R11 control cleared", d, 0);
    chk("R11 rate after second reset", playback_rate, 44100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule